// File: doc/BRIEF.md
# Clock Mode Controller

This block governs how a processor's core clock is derived from a reference clock. It holds one 16-bit mode register on a simple register bus. In divide mode the reference is divided by two or by four. In multiply mode the block drives a 5-bit ratio code and an enable to an external PLL. It then moves the clock select over to the PLL only after a programmed lock interval has run out.

While reset is held, three strap pins are decoded on every reference edge. When reset is released, the register holds the value those straps selected. After that, software may rewrite the register at any time. A status bit reads back whether PLL clocking is active. Reset is synchronous to the reference clock.

Top module: `clkmode_ctrl`

## Requirements
- R1: While `rst_n` is low, the register loads a value decoded from `strap` = {pin1,pin2,pin3}. The codes are: 000 gives 0x0000, 001 gives 0x9007, 010 gives 0x4007, 100 gives 0x1007, 110 gives 0xF007, 101 gives 0xF000, 111 gives 0x0000, and the reserved code 011 gives 0x0000.
- R2: The register answers only at address 0x0058. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: Bit 0 is read-only status (1 means PLL clocking is active). Written values of bit 0 are ignored, and reads return bits 15:1 as stored with the live status in bit 0.
- R4: `pll_en` follows bit 2. `pll_mult` equals bits 15:11: bits 15:12 are the multiplier field and bit 11 is the half-step flag. Multiply mode means bit 2 is 1 and `pll_mult` is nonzero, which gives 31 ratio codes.
- R5: After a multiply-mode write (or a reset release) with lock count L in bits 10:3, `clk_sel` and the status stay 0 for 16·L reference edges and become 1 on edge 16·L+1 after the loading edge.
- R6: A multiply-mode write made while the countdown runs, or while locked, clears `clk_sel` and restarts the countdown from the new L.
- R7: A divide-mode write clears `clk_sel` and the status on the write edge itself.
- R8: `clk_div` has a period of 4 reference cycles when bit 1 is 1 or bits 15:12 are 1111. Otherwise its period is 2 reference cycles.
- R9: `clk_sel` is never 1 unless the register is in multiply mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap | input | 3 | Mode straps {pin1,pin2,pin3} |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pll_en | output | 1 | PLL power enable |
| pll_mult | output | 5 | PLL ratio code |
| clk_sel | output | 1 | 1 = core runs from the PLL, 0 = from the divided reference |
| clk_div | output | 1 | Divided reference clock |

## Verification
The hardest case is a multiply-mode rewrite that lands partway through a lock countdown. It must restart the count and must not let the select rise at the first deadline. The stimulus starts a countdown of 32 edges, rewrites the register after 20 edges, and then checks that the select is still low on edge 32 after the rewrite and high on edge 33. Exact edge counts are also checked for a fresh lock, and strap decoding is exercised by repeated resets over all eight codes.

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h58,
  parameter int              LOCK_SHIFT = 4
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [2:0]        strap,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              pll_en,
  output logic [4:0]        pll_mult,
  output logic              clk_sel,
  output logic              clk_div
);
  localparam int CNT_W = 8 + LOCK_SHIFT;

  logic [15:1]      mode_q;
  logic [CNT_W-1:0] lock_cnt;
  logic             lock_wait;
  logic             pll_active;
  logic [1:0]       div_cnt;
  logic [15:0]      strap_val;
  logic [15:0]      next_val;
  logic             wr_hit;
  logic             rd_hit;
  logic             mult_next;
  logic             div4;

  always_comb begin
    case (strap)
      3'b001:  strap_val = 16'h9007;
      3'b010:  strap_val = 16'h4007;
      3'b100:  strap_val = 16'h1007;
      3'b110:  strap_val = 16'hF007;
      3'b101:  strap_val = 16'hF000;
      default: strap_val = 16'h0000;
    endcase
  end

  assign wr_hit    = bus_sel & bus_wr & (bus_addr == REG_ADDR);
  assign rd_hit    = bus_sel & ~bus_wr & (bus_addr == REG_ADDR);
  assign next_val  = rst_n ? bus_wdata : strap_val;
  assign mult_next = next_val[2] & (next_val[15:11] != 5'd0);

  always_ff @(posedge clk_ref) begin
    if (!rst_n || wr_hit) begin
      mode_q     <= next_val[15:1];
      lock_cnt   <= {next_val[10:3], {LOCK_SHIFT{1'b0}}};
      lock_wait  <= mult_next;
      pll_active <= 1'b0;
    end else if (lock_wait) begin
      if (lock_cnt == '0) begin
        pll_active <= 1'b1;
        lock_wait  <= 1'b0;
      end else begin
        lock_cnt <= lock_cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_ref) begin
    if (!rst_n) div_cnt <= 2'd0;
    else        div_cnt <= div_cnt + 2'd1;
  end

  assign div4      = mode_q[1] | (mode_q[15:12] == 4'hF);
  assign clk_div   = div4 ? div_cnt[1] : div_cnt[0];
  assign pll_en    = mode_q[2];
  assign pll_mult  = mode_q[15:11];
  assign clk_sel   = pll_active;
  assign bus_rdata = rd_hit ? {mode_q, pll_active} : 16'h0000;
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_hit,
  input logic [15:0] wdata,
  input logic        pll_en,
  input logic [4:0]  pll_mult,
  input logic        clk_sel,
  input logic        clk_div,
  input logic        div4
);
  AST_SEL_NEEDS_MULT: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> (pll_en && pll_mult != 5'd0)); // R9

  AST_MULT_WRITE_DROPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[2] && wdata[15:11] != 5'd0) |=> !clk_sel); // R6

  AST_DIV_WRITE_DROPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !(wdata[2] && wdata[15:11] != 5'd0)) |=> !clk_sel); // R7

  AST_SEL_RISES_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> !$past(wr_hit)); // R5

  AST_DIV2_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !div4 && !$past(div4)) |-> (clk_div != $past(clk_div))); // R8
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk(clk_ref), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(bus_wdata),
  .pll_en(pll_en), .pll_mult(pll_mult), .clk_sel(clk_sel),
  .clk_div(clk_div), .div4(div4)
);

// File: tb/clkmode_ctrl_tb.sv
module clkmode_ctrl_tb;
  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap = 3'b000;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        pll_en;
  logic [4:0]  pll_mult;
  logic        clk_sel;
  logic        clk_div;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_ref = ~clk_ref;

  clkmode_ctrl u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .strap(strap),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_en(pll_en), .pll_mult(pll_mult),
    .clk_sel(clk_sel), .clk_div(clk_div)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk_ref);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_ref);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic reset_with(input logic [2:0] s, input logic [15:0] exp, input bit exp_sel);
    logic [15:0] rd;
    @(negedge clk_ref);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    @(negedge clk_ref);
    bus_read(16'h0058, rd);
    check(rd == exp, "R1 strap value", rd, exp);
    check(clk_sel == exp_sel, "R1/R5 select after reset", clk_sel, exp_sel);
  endtask

  task automatic t_straps;
    reset_with(3'b000, 16'h0000, 1'b0);
    check(pll_en == 1'b0, "R4 pll off", pll_en, 0);
    reset_with(3'b001, 16'h9007, 1'b1);
    check(pll_mult == 5'b10010, "R4 ratio x10", pll_mult, 5'b10010);
    reset_with(3'b010, 16'h4007, 1'b1);
    reset_with(3'b100, 16'h1007, 1'b1);
    reset_with(3'b110, 16'hF007, 1'b1);
    reset_with(3'b101, 16'hF000, 1'b0);
    reset_with(3'b111, 16'h0000, 1'b0);
    reset_with(3'b011, 16'h0000, 1'b0);
  endtask

  task automatic t_lock(input int lk);
    logic [15:0] rd;
    bus_write(16'h0058, 16'h4804 | 16'(lk << 3));
    check(pll_en == 1'b1 && pll_mult == 5'b01001, "R4 outputs", {pll_en, pll_mult}, 6'b101001);
    repeat (16 * lk) @(negedge clk_ref);
    check(clk_sel == 1'b0, "R5 still waiting", clk_sel, 0);
    @(negedge clk_ref);
    check(clk_sel == 1'b1, "R5 locked", clk_sel, 1);
    bus_read(16'h0058, rd);
    check(rd[0] == 1'b1, "R3 status live", rd[0], 1);
  endtask

  task automatic t_restart;
    bus_write(16'h0058, 16'h9014);
    repeat (20) @(negedge clk_ref);
    bus_write(16'h0058, 16'h9014);
    repeat (32) @(negedge clk_ref);
    check(clk_sel == 1'b0, "R6 restart held", clk_sel, 0);
    @(negedge clk_ref);
    check(clk_sel == 1'b1, "R6 restart lock", clk_sel, 1);
  endtask

  task automatic t_divide_write;
    logic [15:0] rd;
    bus_write(16'h0058, 16'h0001);
    check(clk_sel == 1'b0, "R7 select cleared", clk_sel, 0);
    bus_read(16'h0058, rd);
    check(rd == 16'h0000, "R3 bit0 write ignored", rd, 0);
    check(pll_en == 1'b0, "R4 pll off after write", pll_en, 0);
    bus_write(16'h0058, 16'h900D);
    check(clk_sel == 1'b0, "R3 status not writable", clk_sel, 0);
    bus_read(16'h0058, rd);
    check(rd == 16'h900C, "R3 readback", rd, 16'h900C);
  endtask

  task automatic t_address;
    logic [15:0] rd;
    bus_write(16'h0058, 16'h0000);
    bus_write(16'h0059, 16'h1234);
    bus_read(16'h0058, rd);
    check(rd == 16'h0000, "R2 other address ignored", rd, 0);
    bus_read(16'h0059, rd);
    check(rd == 16'h0000, "R2 other address reads 0", rd, 0);
  endtask

  task automatic t_div(input logic [15:0] v, input int exp_changes);
    int changes = 0;
    logic prev;
    bus_write(16'h0058, v);
    prev = clk_div;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_ref);
      if (clk_div != prev) changes++;
      prev = clk_div;
    end
    check(changes == exp_changes, "R8 divide period", changes, exp_changes);
  endtask

  initial begin
    t_straps();
    t_lock(1);
    t_lock(3);
    t_restart();
    check(pll_en == 1'b1 && clk_sel == 1'b1, "R9 select in multiply mode", clk_sel, 1);
    t_divide_write();
    t_address();
    t_div(16'h0000, 16);
    t_div(16'hF000, 8);
    t_div(16'h0002, 8);
    check(clk_sel == 1'b0, "R9 no select in divide mode", clk_sel, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule